// File: doc/BRIEF.md
# Clock Buffer Power-Up Sequencer

This block decides when a clock buffer may drive its outputs after power is applied. It watches a supply comparator flag, a power-down request that has already been synchronized, an input-clock detector and a PLL lock flag. It steps through four states: off, settling, waiting and running. Output-enable is high only in the running state. The block feeds that enable to the clock stop controller, which starts and stops the output clocks without glitches.

A free-running timer clock measures two spans. The first is a settling delay after the supply comes up; its length is a parameter and is checked against the allowed window for the chosen timer rate. The second is the start-up bound: it raises a sticky late flag when the outputs are still off too long after the supply became valid. A lock status bit latches when the running state is reached. It is cleared only by a power-down request or by loss of supply. The current state number goes out on a 2-bit port for debug.

Top module: `clkbuf_pwrup_seq`

## Requirements
- R1: While `rst_n` is low, `state_o` is 0 and `oe`, `lock_status` and `late` are all 0.
- R2: In state 0 the machine stays put while `supply_ok` is low. It moves to state 1 on the first clock edge that samples `supply_ok` high.
- R3: State 1 lasts exactly `SETTLE_CYC` timer cycles, then the machine enters state 2. At elaboration, `SETTLE_CYC` must lie between 0.2 ms and 0.3 ms of `TMR_HZ` cycles.
- R4: State 2 moves to state 3 only on an edge that samples `clk_present`=1, `pd_req`=0 and `pll_locked`=1 together. Otherwise it stays in state 2, and that includes a missing input clock.
- R5: `oe` is 1 only while `state_o` is 3, and `oe` never stands high without `lock_status`.
- R6: `lock_status` sets when state 3 is entered. After that it ignores `pll_locked` and `clk_present`. It clears on the edge that samples `pd_req`=1 or `supply_ok`=0.
- R7: In state 3, an edge that samples `pd_req`=1 with the supply valid returns the machine to state 2, so `oe` drops.
- R8: From any state, an edge that samples `supply_ok`=0 returns the machine to state 0 and clears `lock_status`. Supply loss takes priority over every other input.
- R9: `late` rises on the edge `LIMIT_CYC` cycles after state 1 was entered, if state 3 has not been reached by then. It stays high until the machine returns to state 0. Once state 3 has been reached, `late` does not rise again before the next supply loss.
- R10: `state_o` carries the state number in binary: 0 off, 1 settling, 2 waiting, 3 running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above its threshold |
| pd_req | input | 1 | Synchronized power-down request, active high |
| clk_present | input | 1 | Valid input clock detected |
| pll_locked | input | 1 | PLL reports lock to the input clock |
| oe | output | 1 | Output-enable to the clock stop controller |
| lock_status | output | 1 | Latched lock status |
| late | output | 1 | Start-up bound exceeded, sticky |
| state_o | output | 2 | Current state number for debug |

## Verification
The bench finds the exact edge on which the settling window ends and the exact edge on which the start-up bound trips. A counter that is off by one would move state 2 or the late flag one cycle early or late.

In state 2 it tries every partial input combination: power-down held, clock missing, lock missing. A design that decodes the entry condition loosely would enable the outputs without a real input clock.

It drops `pll_locked` and `clk_present` after the running state is reached. A lock status that is not truly latched would fall at that point. It also checks that a power-down request and a supply loss each clear the latch.

Finally it lets the bound expire before lock arrives. The late flag must survive the move to running and clear only when the supply is lost; a non-sticky flag, or one reset by power-down, would show up there.

// File: rtl/clkbuf_pwrup_seq.sv
module clkbuf_pwrup_seq #(
  parameter int TMR_HZ     = 100_000,
  parameter int SETTLE_CYC = 25,
  parameter int LIMIT_CYC  = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       pd_req,
  input  logic       clk_present,
  input  logic       pll_locked,
  output logic       oe,
  output logic       lock_status,
  output logic       late,
  output logic [1:0] state_o
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam int LW = $clog2(LIMIT_CYC + 1);

  typedef enum logic [1:0] {S_OFF = 2'd0, S_SETTLE = 2'd1, S_WAIT = 2'd2, S_RUN = 2'd3} st_t;

  st_t           st, st_nx;
  logic [SW-1:0] settle_cnt;
  logic [LW-1:0] elapsed;
  logic          reached;
  logic          go_run, settle_done, bound_hit, pending;

  assign settle_done = (settle_cnt == SW'(SETTLE_CYC - 1));
  assign go_run      = clk_present && !pd_req && pll_locked;
  assign pending     = (st == S_SETTLE || st == S_WAIT) && !reached;
  assign bound_hit   = pending && !late && (elapsed == LW'(LIMIT_CYC - 1));

  always_comb begin
    st_nx = st;
    if (!supply_ok) st_nx = S_OFF;
    else begin
      unique case (st)
        S_OFF:    st_nx = S_SETTLE;
        S_SETTLE: if (settle_done) st_nx = S_WAIT;
        S_WAIT:   if (go_run) st_nx = S_RUN;
        S_RUN:    if (pd_req) st_nx = S_WAIT;
        default:  st_nx = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_OFF;
      settle_cnt  <= '0;
      elapsed     <= '0;
      reached     <= 1'b0;
      late        <= 1'b0;
      lock_status <= 1'b0;
    end else begin
      st <= st_nx;

      if (st == S_SETTLE) settle_cnt <= settle_cnt + 1'b1;
      else                settle_cnt <= '0;

      if (st == S_OFF) begin
        elapsed <= '0;
        reached <= 1'b0;
        late    <= 1'b0;
      end else begin
        if (pending && !late) elapsed <= elapsed + 1'b1;
        if (bound_hit) late <= 1'b1;
        if (st_nx == S_RUN) reached <= 1'b1;
      end

      if (!supply_ok || pd_req) lock_status <= 1'b0;
      else if (st == S_WAIT && st_nx == S_RUN) lock_status <= 1'b1;
    end
  end

  assign oe      = (st == S_RUN);
  assign state_o = st;
endmodule

// File: rtl/clkbuf_pwrup_seq_chk.sv
module clkbuf_pwrup_seq_chk #(
  parameter int TMR_HZ     = 100_000,
  parameter int SETTLE_CYC = 25,
  parameter int LIMIT_CYC  = 100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       pd_req,
  input logic       clk_present,
  input logic       pll_locked,
  input logic       oe,
  input logic       lock_status,
  input logic       late,
  input logic [1:0] state_o
);
  localparam longint LO_CYC = (longint'(TMR_HZ) * 2 + 9999) / 10000;
  localparam longint HI_CYC = (longint'(TMR_HZ) * 3) / 10000;

  // R3
  initial settle_window_chk: assert (SETTLE_CYC >= LO_CYC && SETTLE_CYC <= HI_CYC);

  // R8
  supply_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (state_o == 2'd0 && !lock_status));

  // R2
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && !supply_ok) |=> state_o == 2'd0);

  // R4
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && supply_ok && (!clk_present || pd_req || !pll_locked)) |=> state_o == 2'd2);

  // R7
  pd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3 && supply_ok && pd_req) |=> (state_o == 2'd2 && !oe));

  // R6
  lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_status && supply_ok && !pd_req) |=> lock_status);

  // R5
  oe_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> lock_status);

  // R9
  late_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (late && supply_ok) |=> late);
endmodule

bind clkbuf_pwrup_seq clkbuf_pwrup_seq_chk #(
  .TMR_HZ(TMR_HZ), .SETTLE_CYC(SETTLE_CYC), .LIMIT_CYC(LIMIT_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pd_req(pd_req),
  .clk_present(clk_present), .pll_locked(pll_locked), .oe(oe),
  .lock_status(lock_status), .late(late), .state_o(state_o)
);

// File: tb/clkbuf_pwrup_seq_tb_top.sv
module clkbuf_pwrup_seq_tb_top;
  localparam int SETTLE = 25;
  localparam int LIMIT  = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic supply_ok = 1'b0, pd_req = 1'b0, clk_present = 1'b0, pll_locked = 1'b0;
  logic oe, lock_status, late;
  logic [1:0] state_o;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  clkbuf_pwrup_seq #(.TMR_HZ(100_000), .SETTLE_CYC(SETTLE), .LIMIT_CYC(LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pd_req(pd_req),
    .clk_present(clk_present), .pll_locked(pll_locked), .oe(oe),
    .lock_status(lock_status), .late(late), .state_o(state_o)
  );

  // {supply, pd, clkp, lock, state[1:0], oe, lock_status}; starts in state 2
  localparam logic [7:0] VEC [10] = '{
    8'b1_1_1_1_10_0_0,  // R4 power-down held
    8'b1_0_0_1_10_0_0,  // R4 no input clock
    8'b1_0_1_0_10_0_0,  // R4 no PLL lock
    8'b1_0_1_1_11_1_1,  // R4 R5 R6 enter running
    8'b1_0_1_0_11_1_1,  // R6 lock dropped, latch holds
    8'b1_0_0_0_11_1_1,  // R6 clock lost, latch holds
    8'b1_1_1_1_10_0_0,  // R7 power-down exits running
    8'b1_0_1_1_11_1_1,  // R4 re-enter running
    8'b0_0_1_1_00_0_0,  // R8 supply loss from running
    8'b1_0_0_0_01_0_0   // R2 back to settling
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(state_o == 2'd0 && !oe && !lock_status && !late, "R1 reset state",
          int'({state_o, oe, lock_status, late}), 0);
    rst_n = 1'b1;
    tick();
    tick();
    check(state_o == 2'd0, "R2 hold off without supply", state_o, 0);

    supply_ok = 1'b1;
    tick();
    check(state_o == 2'd1, "R2 R10 enter settling", state_o, 1);
    repeat (SETTLE - 1) tick();
    check(state_o == 2'd1, "R3 still settling at last cycle", state_o, 1);
    tick();
    check(state_o == 2'd2, "R3 settle window ends", state_o, 2);

    for (int i = 0; i < 10; i++) begin
      {supply_ok, pd_req, clk_present, pll_locked} = VEC[i][7:4];
      tick();
      check(state_o == VEC[i][3:2], $sformatf("R4 R8 vector %0d state", i), state_o, VEC[i][3:2]);
      check(oe == VEC[i][1], $sformatf("R5 vector %0d oe", i), oe, VEC[i][1]);
      check(lock_status == VEC[i][0], $sformatf("R6 vector %0d lock", i), lock_status, VEC[i][0]);
      check(!late, $sformatf("R9 vector %0d late", i), late, 0);
    end

    // R8 supply loss during settling
    tick();
    check(state_o == 2'd1, "R8 settling before drop", state_o, 1);
    supply_ok = 1'b0;
    tick();
    check(state_o == 2'd0, "R8 supply loss in settling", state_o, 0);

    // R9 start-up bound exceeded
    clk_present = 1'b0; pll_locked = 1'b0; pd_req = 1'b0;
    supply_ok = 1'b1;
    tick();
    repeat (LIMIT - 1) tick();
    check(!late && state_o == 2'd2, "R9 late not yet", late, 0);
    tick();
    check(late, "R9 late rises at bound", late, 1);
    clk_present = 1'b1; pll_locked = 1'b1;
    tick();
    check(state_o == 2'd3 && oe, "R4 running after late", state_o, 3);
    check(late, "R9 late sticky in running", late, 1);
    pd_req = 1'b1;
    tick();
    check(late && !lock_status, "R9 R6 late kept, lock cleared by power-down",
          int'({late, lock_status}), 2);
    supply_ok = 1'b0;
    tick();
    tick();
    check(!late && state_o == 2'd0, "R9 late cleared after supply loss", late, 0);

    // R9 reaching running in time suppresses late
    pd_req = 1'b0;
    supply_ok = 1'b1;
    tick();
    repeat (SETTLE) tick();
    tick();
    check(state_o == 2'd3, "R4 running in time", state_o, 3);
    pd_req = 1'b1;
    repeat (LIMIT + 5) tick();
    check(!late && state_o == 2'd2, "R9 no late after reaching running", late, 0);

    // R1 reset from running
    pd_req = 1'b0;
    tick();
    rst_n = 1'b0;
    #1;
    check(state_o == 2'd0 && !oe && !lock_status, "R1 async reset clears", state_o, 0);
    finish_run();
  end
endmodule